// File: doc/BRIEF.md
# Reference-Counted Buffer Reclaimer

This block takes buffer-release requests from a request queue and decides when a packet buffer may go back to the pool. A buffer may be shared by several copies of a multicast packet, so its descriptor carries a reference count. For each release, the block sends an atomic test-and-decrement to descriptor memory. It waits for the count value that memory returns, which is the count as it stood before the decrement. It pushes the buffer handle onto the free list only when that returned value shows that this release dropped the last reference.

When merging is enabled, valid requests are first collected in a small associative table. A release whose handle is already in the table only raises that entry's hit count and makes no memory access. A release for a new handle takes an empty slot. An entry leaves the table in two cases: when the table is full and a new handle arrives, or when the request queue is empty. The entry then costs one decrement by its whole hit count. With merging disabled, every valid request goes straight to memory with a decrement of one, so unicast traffic pays no table overhead.

Top module: `buf_reclaimer`

## Requirements
- R1: A request word whose bit 31 (valid) is 0 is popped in the cycle it is presented and causes no memory request and no free-list push.
- R2: With merging off, a valid request is popped in the cycle it is presented, and the next cycle raises a memory request carrying handle = word bits 23:0 and decrement = 1. Word bits 30:24 (reserved bits and the port field) have no effect.
- R3: When the returned pre-decrement count is less than or equal to the decrement amount, the block pushes the handle to the free list in the cycle after the response. A larger count causes no push.
- R4: A returned count strictly less than the decrement amount still frees the buffer. It also sets the underflow flag, which stays set until reset.
- R5: Only one release is in progress at a time. No request is popped from the moment a memory request is raised until its response has been handled and any resulting free push has been accepted.
- R6: A raised memory request keeps its handle and decrement stable until the cycle in which it is accepted.
- R7: A free-list push keeps its handle stable until the cycle in which it is accepted.
- R8: With merging on, a valid request whose handle matches a table entry is popped in the same cycle, adds one to that entry's hit count, and makes no memory access.
- R9: With merging on, a valid request for a handle not in the table is popped and stored in the lowest-numbered empty slot with a hit count of 1, with no memory access.
- R10: With merging on and all slots full, a request for a new handle is not popped. The lowest-numbered entry is evicted as a memory request with decrement equal to its hit count. The waiting request is accepted once that release completes.
- R11: When no request is presented and the table is not empty, entries are drained one per release, lowest-numbered slot first, each with decrement equal to its hit count. This happens whether merging is on or off.
- R12: After reset there is no memory request, no free push, no underflow flag, and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mergeEn | input | 1 | Enables the associative merging table |
| reqValid | input | 1 | Request queue has a word at its head |
| reqWord | input | 32 | Head request word: bit 31 valid, bits 23:0 handle |
| reqPop | output | 1 | Consumes the head request word at this clock edge |
| memReqValid | output | 1 | Test-and-decrement request pending |
| memReqReady | input | 1 | Memory accepts the request |
| memReqHandle | output | HANDLE_W | Buffer handle to decrement |
| memReqDec | output | CNT_W | Amount to subtract from the count |
| memRspValid | input | 1 | Pre-decrement count is returned |
| memRspCount | input | CNT_W | Count value before the decrement |
| freeValid | output | 1 | Free-list push pending |
| freeReady | input | 1 | Free list accepts the push |
| freeHandle | output | HANDLE_W | Handle being returned to the free list |
| underflowErr | output | 1 | Sticky flag: a returned count was below the decrement |

## Verification
The bench targets the boundary of the free test: a count equal to the decrement must free the buffer, a larger count must not, and a zero count must free the buffer and raise the underflow flag. A design that compared against the value after the decrement would leak buffers or free them twice. It fills all sixteen slots and then offers a seventeenth handle. A design that popped that request anyway would drop a release, and one that evicted the wrong slot would show the wrong handle on the drain. Repeated releases of one handle must leave as a single decrement by the summed count. Memory and free-list back-pressure must hold both outputs steady and block new pops, since a design that let a second release in would interleave two responses.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;
  localparam int REQ_WORD_W  = 32;
  localparam int REQ_VLD_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_PUSH
  } rclmState_t;

  typedef struct packed {
    logic bump;       // add a hit to the matching table entry
    logic alloc;      // place request handle into an empty slot
    logic evict;      // move lowest valid entry into the in-flight register
    logic direct;     // move request handle into the in-flight register
    logic rspLatch;   // memory response is being consumed
  } rclmStrobe_t;
endpackage

// File: rtl/reclaim_datapath.sv
module reclaim_datapath
  import reclaim_pkg::*;
#(
  parameter int HANDLE_W  = 24,
  parameter int CNT_W     = 8,
  parameter int ACC_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  rclmStrobe_t         strobe,
  input  logic [HANDLE_W-1:0] reqHandle,
  input  logic [CNT_W-1:0]    memRspCount,
  output logic                hitAny,
  output logic                hasFree,
  output logic                anyValid,
  output logic                rspFree,
  output logic [HANDLE_W-1:0] curHandle,
  output logic [CNT_W-1:0]    curDec,
  output logic                underflow
);
  localparam int IDX_W = (ACC_DEPTH > 1) ? $clog2(ACC_DEPTH) : 1;

  logic [ACC_DEPTH-1:0] accValid;
  logic [HANDLE_W-1:0]  accHandle [ACC_DEPTH];
  logic [CNT_W-1:0]     accCount  [ACC_DEPTH];
  logic [ACC_DEPTH-1:0] hitVec;
  logic [IDX_W-1:0]     hitIdx, freeIdx, validIdx;

  genvar g;
  generate
    for (g = 0; g < ACC_DEPTH; g++) begin : gCompare
      assign hitVec[g] = accValid[g] && (accHandle[g] == reqHandle);
    end
  endgenerate

  always_comb begin
    hitAny = 1'b0;  hitIdx   = '0;
    hasFree = 1'b0; freeIdx  = '0;
    anyValid = 1'b0; validIdx = '0;
    for (int i = ACC_DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i])    begin hitAny   = 1'b1; hitIdx   = IDX_W'(i); end
      if (!accValid[i]) begin hasFree  = 1'b1; freeIdx  = IDX_W'(i); end
      if (accValid[i])  begin anyValid = 1'b1; validIdx = IDX_W'(i); end
    end
  end

  assign rspFree = (memRspCount <= curDec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accValid  <= '0;
      curHandle <= '0;
      curDec    <= '0;
      underflow <= 1'b0;
      for (int i = 0; i < ACC_DEPTH; i++) begin
        accHandle[i] <= '0;
        accCount[i]  <= '0;
      end
    end else begin
      if (strobe.bump && (accCount[hitIdx] != '1))
        accCount[hitIdx] <= accCount[hitIdx] + CNT_W'(1);
      if (strobe.alloc) begin
        accValid[freeIdx]  <= 1'b1;
        accHandle[freeIdx] <= reqHandle;
        accCount[freeIdx]  <= CNT_W'(1);
      end
      if (strobe.evict) begin
        accValid[validIdx] <= 1'b0;
        curHandle          <= accHandle[validIdx];
        curDec             <= accCount[validIdx];
      end
      if (strobe.direct) begin
        curHandle <= reqHandle;
        curDec    <= CNT_W'(1);
      end
      if (strobe.rspLatch && (memRspCount < curDec))
        underflow <= 1'b1;
    end
  end

  // R4: once raised the underflow flag never drops before reset
  a_r4_underflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);
  // R9: an allocation only ever lands in a slot that was empty
  a_r9_alloc_empty_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !accValid[freeIdx]);
endmodule

// File: rtl/reclaim_control.sv
module reclaim_control
  import reclaim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mergeEn,
  input  logic        reqValid,
  input  logic        reqMarked,
  input  logic        hitAny,
  input  logic        hasFree,
  input  logic        anyValid,
  input  logic        rspFree,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        freeReady,
  output rclmStrobe_t strobe,
  output logic        reqPop,
  output logic        memReqValid,
  output logic        freeValid
);
  rclmState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    reqPop    = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqMarked) begin
            reqPop = 1'b1;
          end else if (mergeEn) begin
            if (hitAny)       begin strobe.bump  = 1'b1; reqPop = 1'b1; end
            else if (hasFree) begin strobe.alloc = 1'b1; reqPop = 1'b1; end
            else                    strobe.evict = 1'b1;
          end else begin
            strobe.direct = 1'b1;
            reqPop        = 1'b1;
          end
        end else if (anyValid) begin
          strobe.evict = 1'b1;
        end
        if (strobe.evict || strobe.direct) stateNext = ST_ISSUE;
      end
      ST_ISSUE: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.rspLatch = 1'b1;
          stateNext       = rspFree ? ST_PUSH : ST_IDLE;
        end
      end
      ST_PUSH: if (freeReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReqValid = (state == ST_ISSUE);
  assign freeValid   = (state == ST_PUSH);

  // R1: an unmarked head word is always consumed at once when idle-able
  a_r1_discard_pops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqMarked && !memReqValid && !freeValid && state != ST_WAIT) |-> reqPop);
  // R3: a free push only follows a consumed response
  a_r3_push_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freeValid) |-> $past(memRspValid));
endmodule

// File: rtl/buf_reclaimer.sv
module buf_reclaimer
  import reclaim_pkg::*;
#(
  parameter int HANDLE_W  = 24,
  parameter int CNT_W     = 8,
  parameter int ACC_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mergeEn,
  input  logic                  reqValid,
  input  logic [REQ_WORD_W-1:0] reqWord,
  output logic                  reqPop,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [HANDLE_W-1:0]   memReqHandle,
  output logic [CNT_W-1:0]      memReqDec,
  input  logic                  memRspValid,
  input  logic [CNT_W-1:0]      memRspCount,
  output logic                  freeValid,
  input  logic                  freeReady,
  output logic [HANDLE_W-1:0]   freeHandle,
  output logic                  underflowErr
);
  rclmStrobe_t   strobe;
  logic          hitAny, hasFree, anyValid, rspFree;
  logic [HANDLE_W-1:0] curHandle;
  logic [CNT_W-1:0]    curDec;
  logic          unusedFields;

  assign unusedFields = ^reqWord[REQ_VLD_BIT-1:HANDLE_W];

  reclaim_control u_ctl (
    .clk(clk), .rstN(rstN), .mergeEn(mergeEn), .reqValid(reqValid),
    .reqMarked(reqWord[REQ_VLD_BIT]), .hitAny(hitAny), .hasFree(hasFree),
    .anyValid(anyValid), .rspFree(rspFree), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .freeReady(freeReady), .strobe(strobe),
    .reqPop(reqPop), .memReqValid(memReqValid), .freeValid(freeValid)
  );

  reclaim_datapath #(.HANDLE_W(HANDLE_W), .CNT_W(CNT_W), .ACC_DEPTH(ACC_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqHandle(reqWord[HANDLE_W-1:0]),
    .memRspCount(memRspCount), .hitAny(hitAny), .hasFree(hasFree),
    .anyValid(anyValid), .rspFree(rspFree), .curHandle(curHandle),
    .curDec(curDec), .underflow(underflowErr)
  );

  assign memReqHandle = curHandle;
  assign memReqDec    = curDec;
  assign freeHandle   = curHandle;

  // R5: nothing is popped while a release is outstanding
  a_r5_no_pop_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || freeValid) |-> !reqPop);
  // R6: a stalled memory request keeps its contents
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqHandle) && $stable(memReqDec)));
  // R7: a stalled free push keeps its handle
  a_r7_free_hold: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && !freeReady) |=> (freeValid && $stable(freeHandle)));
  // R8: a pop in merge mode never triggers a memory access next cycle
  a_r8_merge_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqPop && mergeEn) |=> !memReqValid);
endmodule

// File: tb/test_buf_reclaimer.sv
module test_buf_reclaimer;
  localparam int HW = 24;
  localparam int CW = 8;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [31:0] word;
    logic [7:0]  rsp;
    logic        expMem;
    logic        expFree;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h8100_0A01, 8'd1, 1'b1, 1'b1},
    '{32'h8200_0B02, 8'd3, 1'b1, 1'b0},
    '{32'h0F12_3456, 8'd0, 1'b0, 1'b0},
    '{32'hFF00_0C03, 8'd2, 1'b1, 1'b0},
    '{32'h8A00_0D04, 8'd1, 1'b1, 1'b1},
    '{32'h7FFF_FFFF, 8'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mergeEn = 1'b0, reqValid = 1'b0, memReqReady = 1'b0;
  logic memRspValid = 1'b0, freeReady = 1'b0;
  logic [31:0] reqWord = '0;
  logic [CW-1:0] memRspCount = '0;
  logic reqPop, memReqValid, freeValid, underflowErr;
  logic [HW-1:0] memReqHandle, freeHandle;
  logic [CW-1:0] memReqDec;

  int nCmp = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  buf_reclaimer #(.HANDLE_W(HW), .CNT_W(CW), .ACC_DEPTH(DEPTH)) i_buf_reclaimer (
    .clk(clk), .rstN(rstN), .mergeEn(mergeEn), .reqValid(reqValid), .reqWord(reqWord),
    .reqPop(reqPop), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqHandle(memReqHandle), .memReqDec(memReqDec), .memRspValid(memRspValid),
    .memRspCount(memRspCount), .freeValid(freeValid), .freeReady(freeReady),
    .freeHandle(freeHandle), .underflowErr(underflowErr)
  );

  task automatic checkEq(string req, string what, longint act, longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Entered at a negedge; returns at a negedge with the block idle.
  task automatic serviceMem(string req, longint expH, longint expD, int rsp, bit expFree);
    int waitN = 0;
    while (!memReqValid && waitN < 50) begin
      @(negedge clk);
      waitN++;
    end
    checkEq(req, "memReqValid", memReqValid, 1);
    checkEq(req, "memReqHandle", memReqHandle, expH);
    checkEq(req, "memReqDec", memReqDec, expD);
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    checkEq(req, "memReqValid after accept", memReqValid, 0);
    memRspValid = 1'b1;
    memRspCount = CW'(rsp);
    @(negedge clk);
    memRspValid = 1'b0;
    checkEq(req, "freeValid", freeValid, expFree);
    if (expFree) begin
      checkEq(req, "freeHandle", freeHandle, expH);
      freeReady = 1'b1;
      @(negedge clk);
      freeReady = 1'b0;
      checkEq(req, "freeValid after accept", freeValid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checkEq("R12", "memReqValid in reset", memReqValid, 0);
    checkEq("R12", "freeValid in reset", freeValid, 0);
    checkEq("R12", "underflowErr in reset", underflowErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      checkEq("R12", "memReqValid idle with empty table", memReqValid, 0);
    end

    // Vector table, merging off: R1, R2, R3
    for (int i = 0; i < 6; i++) begin
      reqWord  = VEC[i].word;
      reqValid = 1'b1;
      #1;
      checkEq(VEC[i].expMem ? "R2" : "R1", "reqPop", reqPop, 1);
      @(negedge clk);
      reqValid = 1'b0;
      if (VEC[i].expMem) begin
        serviceMem("R3", VEC[i].word[HW-1:0], 1, VEC[i].rsp, VEC[i].expFree);
      end else begin
        repeat (3) begin
          @(negedge clk);
          checkEq("R1", "memReqValid after discard", memReqValid, 0);
          checkEq("R1", "freeValid after discard", freeValid, 0);
        end
      end
    end
    checkEq("R4", "underflowErr before any underflow", underflowErr, 0);

    // R4: count below decrement frees and flags
    reqWord = 32'h8000_0E05; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    serviceMem("R4", 24'h000E05, 1, 0, 1'b1);
    checkEq("R4", "underflowErr set", underflowErr, 1);
    reqWord = 32'h8000_0E06; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    serviceMem("R4", 24'h000E06, 1, 1, 1'b1);
    checkEq("R4", "underflowErr sticky", underflowErr, 1);

    // R6, R7, R5: back-pressure and single release in progress
    reqWord = 32'h8000_0F06; reqValid = 1'b1;
    @(negedge clk);
    reqWord = 32'h8000_1111;
    repeat (3) begin
      #1;
      checkEq("R6", "memReqValid held", memReqValid, 1);
      checkEq("R6", "memReqHandle held", memReqHandle, 24'h000F06);
      checkEq("R5", "no pop while request pending", reqPop, 0);
      @(negedge clk);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    memRspValid = 1'b1; memRspCount = 8'd1;
    #1;
    checkEq("R5", "no pop while awaiting response", reqPop, 0);
    @(negedge clk);
    memRspValid = 1'b0;
    repeat (2) begin
      #1;
      checkEq("R7", "freeValid held", freeValid, 1);
      checkEq("R7", "freeHandle held", freeHandle, 24'h000F06);
      checkEq("R5", "no pop while push pending", reqPop, 0);
      @(negedge clk);
    end
    freeReady = 1'b1;
    @(negedge clk);
    freeReady = 1'b0;
    #1;
    checkEq("R5", "waiting request popped after push", reqPop, 1);
    @(negedge clk);
    reqValid = 1'b0;
    serviceMem("R2", 24'h001111, 1, 5, 1'b0);

    // R8, R9, R11: merging of repeated handles, then drain
    mergeEn = 1'b1;
    reqWord = 32'h8000_00AA; reqValid = 1'b1;
    #1; checkEq("R9", "first handle allocated", reqPop, 1);
    @(negedge clk);
    #1; checkEq("R8", "repeat handle merged", reqPop, 1);
    checkEq("R8", "no memory access on merge", memReqValid, 0);
    @(negedge clk);
    #1; checkEq("R8", "repeat handle merged again", reqPop, 1);
    @(negedge clk);
    reqWord = 32'h8000_00BB;
    #1; checkEq("R9", "second handle allocated", reqPop, 1);
    checkEq("R8", "still no memory access", memReqValid, 0);
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R9", "no memory access on allocate", memReqValid, 0);
    @(negedge clk);
    serviceMem("R11", 24'h0000AA, 3, 3, 1'b1);
    serviceMem("R11", 24'h0000BB, 1, 2, 1'b0);
    repeat (3) begin
      @(negedge clk);
      checkEq("R11", "table empty after drain", memReqValid, 0);
    end

    // R10: full table, then drain with merging off (R11)
    reqValid = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      reqWord = 32'h8000_0100 + 32'(k);
      #1; checkEq("R9", "fill slot", reqPop, 1);
      @(negedge clk);
    end
    reqWord = 32'h8000_0200;
    #1; checkEq("R10", "no pop when table full", reqPop, 0);
    @(negedge clk);
    serviceMem("R10", 24'h000100, 1, 1, 1'b1);
    #1; checkEq("R10", "waiting request accepted after eviction", reqPop, 1);
    @(negedge clk);
    reqValid = 1'b0;
    mergeEn  = 1'b0;
    @(negedge clk);
    serviceMem("R11", 24'h000200, 1, 1, 1'b1);
    for (int k = 1; k < DEPTH; k++)
      serviceMem("R11", 24'h000100 + 24'(k), 1, 1, 1'b1);
    repeat (3) begin
      @(negedge clk);
      checkEq("R11", "table empty after full drain", memReqValid, 0);
    end

    // R12: reset clears the sticky flag
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkEq("R12", "underflowErr cleared by reset", underflowErr, 0);
    checkEq("R12", "freeValid after reset", freeValid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule